// File: doc/BRIEF.md
# Multi-stream rate governor parameter calculator

This block works out the pacing parameters that a multi-stream display link needs for one video stream. It takes a pixel clock in kHz, a pixel depth in bits, a link symbol rate, an active lane count and a payload bandwidth number. From these it finds two slot counts. The lower count is the number of slots the stream needs at exactly its own bandwidth. The upper count is the limit that the bandwidth number allows. The block aims for the point halfway between them.

That midpoint is rounded down to a grid of 1/(256*lanes) of a slot and then scaled by the lane count. The result is a symbol count per transfer packet with a whole part and an eighth-bit fractional enumerator. The block gives these as two fields and also as one packed 32-bit register word, ready to be written into a stream's governor register. All division goes through a single shared bit-serial divider, so each request takes a fixed number of cycles.

Requests arrive on a valid/ready input. Ready is high only while the block is idle. A request is accepted on the clock edge where valid and ready are both high. A valid offered while ready is low is not taken and leaves no trace. Results have no back-pressure. A one-cycle done pulse marks a new result, and the result fields then stay unchanged until the next done pulse.

Top module: `rg_calc`

## Requirements
- R1: Let D = lclk*lanes, A = floor(pclk*bpp*8*2^32/D) and B = floor(pbn*54000*2^32/D). The raw target T is floor((A+B)/2), a number with 32 fractional bits. Its whole part is W = floor(T/2^32) and its fraction is F = T mod 2^32.
- R2: When F is nonzero, the step enumerator is E = floor(F*256*lanes/2^32).
- R3: When F is zero, E is forced to 256*lanes, which moves the target up by one full slot.
- R4: x_int equals (W*lanes + floor(E/256)) mod 2^16, and y_frac equals E mod 256.
- R5: rg_word carries y_frac in bits 7:0, zero in bits 15:8 and x_int in bits 31:16.
- R6: req_ready is high exactly when no request is in progress. A req_valid seen while req_ready is low does not start a job, does not produce a done pulse and does not change the result.
- R7: Every accepted request produces exactly one res_done pulse, one cycle wide, no later than 2*(32+32)+8 clock cycles after the accepting edge. A new request can be accepted in the same cycle that res_done is high.
- R8: If lanes or lclk is 0, res_err is 1, x_int, y_frac and rg_word are 0, and res_done still pulses. Otherwise res_err is 0.
- R9: x_int, y_frac, rg_word and res_err change only in a cycle where res_done is high. Input values that change after a request has been accepted have no effect on its result.
- R10: After reset, req_ready is 1, res_done is 0, res_err is 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| pclk_khz | input | 20 | Pixel clock in kHz |
| bpp | input | 6 | Bits per pixel |
| lclk | input | 20 | Link symbol rate, in the same unit scale as the pixel clock |
| lanes | input | 3 | Active lane count |
| pbn | input | 16 | Payload bandwidth number |
| res_done | output | 1 | One-cycle pulse marking a new result |
| res_err | output | 1 | Last result came from a zero denominator |
| x_int | output | 16 | Whole symbols per transfer packet |
| y_frac | output | 8 | Fractional enumerator, in 1/256 steps |
| rg_word | output | 32 | Packed governor register word |

## Verification
The accept path and the result path can be active in the same cycle. The cycle in which res_done rises is also the first cycle in which req_ready is high again. To provoke this, the bench holds req_valid high with a second job, ready and waiting, while the first job runs. The first job's result is then judged against its own expected value when res_done is high, and the second job must be accepted on that same edge and return its own value. This overlap is exercised on both the normal path and the zero-denominator path.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int RG_XINT_W = 16;
  localparam int RG_YFRAC_W = 8;
  localparam int RG_WORD_W = 32;
  localparam int RG_PBN_SCALE = 54000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_LOAD_A,
    S_RUN_A,
    S_LOAD_B,
    S_RUN_B,
    S_FINISH
  } rg_state_t;
endpackage

// File: rtl/rg_div.sv
module rg_div #(
  parameter int NW = 64,
  parameter int DW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] sh;
  logic [DW-1:0] dq;
  logic [CW-1:0] cnt;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  always_comb begin
    trial = {rem, sh[NW-1]};
    ge    = (trial >= {1'b0, dq});
    diff  = trial - {1'b0, dq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      sh   <= '0;
      dq   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      rem  <= '0;
      sh   <= num;
      dq   <= den;
      cnt  <= CW'(NW);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      rem <= ge ? DW'(diff) : DW'(trial);
      sh  <= {sh[NW-2:0], ge};
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = sh;

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < dq)); // R1
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R7
  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/rg_quant.sv
module rg_quant
  import rg_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int FRAC_W = 32,
  parameter int LANE_W = 3
) (
  input  logic [INT_W+FRAC_W-1:0] raw,
  input  logic [LANE_W-1:0]       lanes,
  output logic [RG_XINT_W-1:0]    x_int,
  output logic [RG_YFRAC_W-1:0]   y_frac
);
  localparam int EW = LANE_W + 9;
  localparam int PW = FRAC_W + EW;

  logic [INT_W-1:0]  whole;
  logic [FRAC_W-1:0] frac;
  logic [EW-1:0]     scale;
  logic [PW-1:0]     prod;
  logic [EW-1:0]     step;

  always_comb begin
    whole = raw[INT_W+FRAC_W-1:FRAC_W];
    frac  = raw[FRAC_W-1:0];
    scale = EW'(lanes) << 8;
    prod  = PW'(frac) * PW'(scale);
    if (frac == '0) step = scale;
    else            step = EW'(prod >> FRAC_W);
    x_int  = RG_XINT_W'(whole) * RG_XINT_W'(lanes) + RG_XINT_W'(step >> 8);
    y_frac = RG_YFRAC_W'(step);
  end

  always_comb begin
    AST_STEP_IN_RANGE: assert (step <= scale); // R2
  end
endmodule

// File: rtl/rg_calc.sv
module rg_calc
  import rg_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int BPP_W  = 6,
  parameter int LCLK_W = 20,
  parameter int LANE_W = 3,
  parameter int PBN_W  = 16,
  parameter int FRAC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PCLK_W-1:0]     pclk_khz,
  input  logic [BPP_W-1:0]      bpp,
  input  logic [LCLK_W-1:0]     lclk,
  input  logic [LANE_W-1:0]     lanes,
  input  logic [PBN_W-1:0]      pbn,
  output logic                  res_done,
  output logic                  res_err,
  output logic [RG_XINT_W-1:0]  x_int,
  output logic [RG_YFRAC_W-1:0] y_frac,
  output logic [RG_WORD_W-1:0]  rg_word
);
  localparam int NUM_A_W = PCLK_W + BPP_W + 3;
  localparam int NUM_B_W = PBN_W + 16;
  localparam int NUM_W   = (NUM_A_W > NUM_B_W) ? NUM_A_W : NUM_B_W;
  localparam int DIV_W   = NUM_W + FRAC_W;
  localparam int DEN_W   = LCLK_W + LANE_W;

  rg_state_t state;

  logic [PCLK_W-1:0] pclk_q;
  logic [BPP_W-1:0]  bpp_q;
  logic [LCLK_W-1:0] lclk_q;
  logic [LANE_W-1:0] lanes_q;
  logic [PBN_W-1:0]  pbn_q;
  logic              zero_q;
  logic [DIV_W-1:0]  qa_q;
  logic [DIV_W-1:0]  qb_q;

  logic [DEN_W-1:0]  den;
  logic [NUM_W-1:0]  num_a;
  logic [NUM_W-1:0]  num_b;
  logic [DIV_W-1:0]  div_num;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [DIV_W-1:0]  div_quo;
  logic [DIV_W:0]    sum;
  logic [DIV_W-1:0]  raw;
  logic [RG_XINT_W-1:0]  q_x;
  logic [RG_YFRAC_W-1:0] q_y;

  always_comb begin
    den     = DEN_W'(lclk_q) * DEN_W'(lanes_q);
    num_a   = (NUM_W'(pclk_q) * NUM_W'(bpp_q)) << 3;
    num_b   = NUM_W'(pbn_q) * NUM_W'(RG_PBN_SCALE);
    div_num = (state == S_LOAD_B) ? {num_b, {FRAC_W{1'b0}}} : {num_a, {FRAC_W{1'b0}}};
    div_start = (state == S_LOAD_A) || (state == S_LOAD_B);
    sum     = {1'b0, qa_q} + {1'b0, qb_q};
    raw     = DIV_W'(sum >> 1);
  end

  assign req_ready = (state == S_IDLE);

  rg_div #(.NW(DIV_W), .DW(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (den),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  rg_quant #(.INT_W(NUM_W), .FRAC_W(FRAC_W), .LANE_W(LANE_W)) u_quant (
    .raw    (raw),
    .lanes  (lanes_q),
    .x_int  (q_x),
    .y_frac (q_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pclk_q   <= '0;
      bpp_q    <= '0;
      lclk_q   <= '0;
      lanes_q  <= '0;
      pbn_q    <= '0;
      zero_q   <= 1'b0;
      qa_q     <= '0;
      qb_q     <= '0;
      res_done <= 1'b0;
      res_err  <= 1'b0;
      x_int    <= '0;
      y_frac   <= '0;
    end else begin
      res_done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            pclk_q  <= pclk_khz;
            bpp_q   <= bpp;
            lclk_q  <= lclk;
            lanes_q <= lanes;
            pbn_q   <= pbn;
            state   <= S_CHECK;
          end
        end
        S_CHECK: begin
          zero_q <= (den == '0);
          state  <= (den == '0) ? S_FINISH : S_LOAD_A;
        end
        S_LOAD_A: state <= S_RUN_A;
        S_RUN_A: begin
          if (div_done) begin
            qa_q  <= div_quo;
            state <= S_LOAD_B;
          end
        end
        S_LOAD_B: state <= S_RUN_B;
        S_RUN_B: begin
          if (div_done) begin
            qb_q  <= div_quo;
            state <= S_FINISH;
          end
        end
        S_FINISH: begin
          res_done <= 1'b1;
          res_err  <= zero_q;
          x_int    <= zero_q ? '0 : q_x;
          y_frac   <= zero_q ? '0 : q_y;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rg_word = {x_int, {(RG_WORD_W - RG_XINT_W - RG_YFRAC_W){1'b0}}, y_frac};

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy); // R7
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done); // R7
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> req_ready); // R7
  AST_ERR_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (x_int == '0 && y_frac == '0)); // R8
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rg_word) || !$stable(res_err)) |-> res_done); // R9
endmodule

// File: tb/rg_calc_test.sv
module rg_calc_test;
  typedef struct {
    logic [15:0] x;
    logic [7:0]  y;
    logic        err;
    int          acc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] pclk_khz = '0;
  logic [5:0]  bpp = '0;
  logic [19:0] lclk = '0;
  logic [2:0]  lanes = '0;
  logic [15:0] pbn = '0;
  logic        res_done, res_err;
  logic [15:0] x_int;
  logic [7:0]  y_frac;
  logic [31:0] rg_word;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_done = 0;
  int n_jobs = 0;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rg_calc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .pclk_khz(pclk_khz), .bpp(bpp), .lclk(lclk), .lanes(lanes), .pbn(pbn),
    .res_done(res_done), .res_err(res_err), .x_int(x_int), .y_frac(y_frac),
    .rg_word(rg_word)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Expected values straight from R1..R4 and R8.
  function automatic exp_t model(input logic [19:0] pc, input logic [5:0] bp,
                                 input logic [19:0] lc, input logic [2:0] ln,
                                 input logic [15:0] pb);
    exp_t r;
    logic [127:0] d, a, b, t, w, f, e, xf;
    d = 128'(lc) * 128'(ln);
    r.acc = 0;
    if (d == 0) begin
      r.x = '0; r.y = '0; r.err = 1'b1;
      return r;
    end
    a = ((128'(pc) * 128'(bp) * 128'd8) << 32) / d;
    b = ((128'(pb) * 128'd54000) << 32) / d;
    t = (a + b) >> 1;
    w = t >> 32;
    f = t & 128'hFFFF_FFFF;
    if (f == 0) e = 128'd256 * 128'(ln);
    else        e = (f * 128'd256 * 128'(ln)) >> 32;
    xf = w * 128'(ln) + (e >> 8);
    r.x = xf[15:0];
    r.y = e[7:0];
    r.err = 1'b0;
    return r;
  endfunction

  task automatic push_job(input logic [19:0] pc, input logic [5:0] bp,
                          input logic [19:0] lc, input logic [2:0] ln,
                          input logic [15:0] pb);
    exp_t ex;
    ex = model(pc, bp, lc, ln, pb);
    @(negedge clk);
    pclk_khz = pc; bpp = bp; lclk = lc; lanes = ln; pbn = pb;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    ex.acc = cyc;
    sb.push_back(ex);
    n_jobs++;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: later input changes must not reach this job's result
    pclk_khz = 20'($urandom); bpp = 6'($urandom); lclk = 20'($urandom);
    lanes = 3'($urandom); pbn = 16'($urandom);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_done) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R6 unexpected done", 64'(rg_word), 64'hx);
      end else begin
        exp_t ex;
        ex = sb.pop_front();
        check(res_err == ex.err, "R8 err flag", 64'(res_err), 64'(ex.err));
        check(x_int == ex.x, "R4 x_int", 64'(x_int), 64'(ex.x));
        check(y_frac == ex.y, "R4 y_frac", 64'(y_frac), 64'(ex.y));
        check(rg_word == {ex.x, 8'h00, ex.y}, "R5 packed word", 64'(rg_word),
              64'({ex.x, 8'h00, ex.y}));
        check((cyc - ex.acc - 1) <= 136, "R7 latency", 64'(cyc - ex.acc - 1), 64'd136);
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 ready", 64'(req_ready), 64'd1);
    check(res_done == 1'b0, "R10 done", 64'(res_done), 64'd0);
    check(res_err == 1'b0, "R10 err", 64'(res_err), 64'd0);
    check(rg_word == '0, "R10 word", 64'(rg_word), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 typical modes
    push_job(20'd148500, 6'd24, 20'd270000, 3'd4, 16'd532);
    drain();
    push_job(20'd594000, 6'd30, 20'd810000, 3'd4, 16'd2130);
    drain();
    push_job(20'd74250, 6'd24, 20'd162000, 3'd1, 16'd266);
    drain();
    push_job(20'd25175, 6'd18, 20'd270000, 3'd2, 16'd70);
    drain();
    // R3 whole-number raw target: forced enumerator
    push_job(20'd1000, 6'd8, 20'd1000, 3'd1, 16'd0);
    drain();
    push_job(20'd3000, 6'd8, 20'd1000, 3'd3, 16'd0);
    drain();
    // R4 x_int wraps modulo 2^16
    push_job(20'd1, 6'd8, 20'd1, 3'd4, 16'd1000);
    drain();
    // R8 zero denominators
    push_job(20'd148500, 6'd24, 20'd270000, 3'd0, 16'd532);
    drain();
    check(res_err == 1'b1 && rg_word == '0, "R8 held error", 64'(rg_word), 64'd0);
    push_job(20'd148500, 6'd24, 20'd0, 3'd4, 16'd532);
    drain();

    // R6 valid while busy is ignored
    push_job(20'd297000, 6'd24, 20'd540000, 3'd4, 16'd1064);
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R6 busy not ready", 64'(req_ready), 64'd0);
    pclk_khz = 20'd5; bpp = 6'd1; lclk = 20'd7; lanes = 3'd1; pbn = 16'd9;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    drain();
    repeat (160) @(negedge clk);
    check(n_done == n_jobs, "R6 done count", 64'(n_done), 64'(n_jobs));

    // R7 back-to-back: second accepted in the done cycle
    push_job(20'd148500, 6'd24, 20'd270000, 3'd2, 16'd540);
    push_job(20'd241500, 6'd24, 20'd540000, 3'd4, 16'd870);
    push_job(20'd100000, 6'd24, 20'd0, 3'd2, 16'd400);
    push_job(20'd65000, 6'd16, 20'd162000, 3'd2, 16'd200);
    drain();
    check(n_done == n_jobs, "R7 one done per job", 64'(n_done), 64'(n_jobs));
    check(rg_word == {x_int, 8'h00, y_frac}, "R5 field layout", 64'(rg_word),
          64'({x_int, 8'h00, y_frac}));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_jobs);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule